// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read

This block is a first-in first-out buffer whose write port and read port run on separate clocks. The two clocks may be unrelated, equal in frequency with unknown phase, or integer multiples of each other. A small dual-port storage array holds the words. Write and read positions are kept as binary counters, one bit wider than the address. They are copied into the other clock domain as Gray code through two-flop synchronizers. Each side works out its own occupancy from its own pointer and the synchronized copy of the other pointer. Full, almost-full, empty and almost-empty are derived from that occupancy. The full flag lives on the write side and the empty flag on the read side, so a flag can clear a few cycles late but never clears early.

A parameter selects the read behaviour. In standard mode a word is only moved to the data output when the reader requests it. In fall-through mode a one-word output register is refilled on its own, so the oldest word is already on the data output when empty goes low. Requests made at the wrong time do no harm. Writing into a full buffer, or reading from an empty one, is refused and raises a one-cycle error strobe. Stored words and pointers stay as they were.

Top module: `dual_clock_fifo`

## Requirements
- R1: While either reset is held, and on the first cycle after release with no traffic, rd_empty is 1, wr_full is 0, both counts are 0, both error strobes are 0 and rd_data is 0.
- R2: Words leave in exactly the order they were accepted, with their values unchanged. rd_data does not change in a cycle where rd_empty is 0 and rd_en is 0.
- R3: wr_full is 1 exactly when wr_count equals 2^ADDR_W. A write requested while wr_full is 1 is dropped, and the write pointer and stored words stay unchanged.
- R4: A read requested while rd_empty is 1 is refused, and no word is consumed.
- R5: wr_err is 1 for exactly the one write-clock cycle after an edge where wr_en and wr_full were both 1. rd_err is 1 for exactly the one read-clock cycle after an edge where rd_en and rd_empty were both 1. Neither strobe is ever 1 otherwise.
- R6: wr_almost_full is 1 exactly when wr_count is at least AFULL_LVL (1 to 2^ADDR_W).
- R7: rd_almost_empty is 1 exactly when rd_count is at most AEMPTY_LVL (0 to 2^ADDR_W-1).
- R8: With READ_MODE = RD_STANDARD (0), rd_empty is 1 exactly when the read side sees no stored word. An accepted read puts the oldest word on rd_data at the next read-clock edge.
- R9: With READ_MODE = RD_FALLTHRU (1), rd_empty is 0 exactly when the output register holds a word. That register is refilled from storage without rd_en whenever it is empty or being read. The first word after empty therefore appears with no read request.
- R10: A pointer moves to the other domain through a Gray-coded two-flop synchronizer. wr_count equals the words accepted minus the words removed as of two write edges earlier. Storage sees a write as present on the read side two read edges after the write edge.
- R11: In standard mode, rd_count is the number of words the read side sees in storage. In fall-through mode, rd_count is that number plus 1 when the output register holds a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No room for another word |
| wr_almost_full | output | 1 | Occupancy at or above AFULL_LVL |
| wr_err | output | 1 | One-cycle strobe for a refused write |
| wr_count | output | ADDR_W+1 | Occupancy seen from the write side |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| rd_empty | output | 1 | No word available to the reader |
| rd_almost_empty | output | 1 | Occupancy at or below AEMPTY_LVL |
| rd_err | output | 1 | One-cycle strobe for a refused read |
| rd_count | output | ADDR_W+1 | Occupancy seen from the read side |

## Verification
The properties assume that both resets are asserted together at start-up. They also assume that wr_en and rd_en carry known values once their domain has left reset. The stimulus drives every input on the falling clock edge and releases both resets on the same edge. It clocks both domains from one source, so the synchronizer delay is fixed and the model can follow it cycle by cycle. Overflow and underflow requests are made on purpose, both in directed bursts and in the random phases, because the block must tolerate them.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic {
      RD_STANDARD = 1'b0,
      RD_FALLTHRU = 1'b1
   } dcf_rd_mode_e;
endpackage

// File: rtl/dcf_ptr_sync.sv
// Two-flop capture of a Gray pointer into the destination clock, then decode to binary.
module dcf_ptr_sync #(
   parameter int PW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);
   logic [PW-1:0] meta_q;
   logic [PW-1:0] gray_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         gray_q <= '0;
      end else begin
         meta_q <= gray_in;
         gray_q <= meta_q;
      end
   end

   // binary bit i is the XOR of all Gray bits at or above i
   for (genvar i = 0; i < PW; i++) begin : g_dec
      assign bin_out[i] = ^(gray_q >> i);
   end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
   parameter int ADDR_W    = 4,
   parameter int AFULL_LVL = 12
) (
   input  logic            wclk,
   input  logic            wrst_n,
   input  logic            wr_en,
   input  logic [ADDR_W:0] rptr_sync,
   output logic [ADDR_W:0] wptr_bin,
   output logic [ADDR_W:0] wptr_gray,
   output logic            mem_we,
   output logic            full,
   output logic            afull,
   output logic            werr,
   output logic [ADDR_W:0] wcount
);
   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   logic [PW-1:0] wptr_q, wgray_q, wptr_nx;
   logic          werr_q;

   assign wcount  = wptr_q - rptr_sync;
   assign full    = (wcount == PW'(DEPTH));
   assign afull   = (wcount >= PW'(AFULL_LVL));
   assign mem_we  = wr_en & ~full;
   assign wptr_nx = wptr_q + PW'(1);

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wptr_q  <= '0;
         wgray_q <= '0;
         werr_q  <= 1'b0;
      end else begin
         werr_q <= wr_en & full;
         if (mem_we) begin
            wptr_q  <= wptr_nx;
            wgray_q <= wptr_nx ^ (wptr_nx >> 1);
         end
      end
   end

   assign wptr_bin  = wptr_q;
   assign wptr_gray = wgray_q;
   assign werr      = werr_q;
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
   parameter int                   DATA_W     = 8,
   parameter int                   ADDR_W     = 4,
   parameter int                   AEMPTY_LVL = 3,
   parameter dcf_pkg::dcf_rd_mode_e READ_MODE = dcf_pkg::RD_STANDARD
) (
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rd_en,
   input  logic [ADDR_W:0]   wptr_sync,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rptr_bin,
   output logic [ADDR_W:0]   rptr_gray,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              aempty,
   output logic              rerr,
   output logic [ADDR_W:0]   rcount
);
   localparam int PW = ADDR_W + 1;

   logic [PW-1:0]     rptr_q, rgray_q, rptr_nx, memcnt;
   logic [DATA_W-1:0] data_q;
   logic              mem_empty, pop, rerr_q;

   assign memcnt    = wptr_sync - rptr_q;
   assign mem_empty = (memcnt == '0);
   assign rptr_nx   = rptr_q + PW'(1);

   if (READ_MODE == dcf_pkg::RD_STANDARD) begin : g_std
      assign pop    = rd_en & ~mem_empty;
      assign empty  = mem_empty;
      assign rcount = memcnt;
   end else begin : g_fwft
      logic hold_q;
      assign pop    = ~mem_empty & (~hold_q | rd_en);
      assign empty  = ~hold_q;
      assign rcount = memcnt + PW'(hold_q);
      always_ff @(posedge rclk or negedge rrst_n) begin
         if (!rrst_n)    hold_q <= 1'b0;
         else if (pop)   hold_q <= 1'b1;
         else if (rd_en) hold_q <= 1'b0;
      end
   end

   assign aempty = (rcount <= PW'(AEMPTY_LVL));

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rptr_q  <= '0;
         rgray_q <= '0;
         data_q  <= '0;
         rerr_q  <= 1'b0;
      end else begin
         rerr_q <= rd_en & empty;
         if (pop) begin
            rptr_q  <= rptr_nx;
            rgray_q <= rptr_nx ^ (rptr_nx >> 1);
            data_q  <= mem_rdata;
         end
      end
   end

   assign raddr     = rptr_q[ADDR_W-1:0];
   assign rptr_bin  = rptr_q;
   assign rptr_gray = rgray_q;
   assign rd_data   = data_q;
   assign rerr      = rerr_q;
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
   parameter int                    DATA_W     = 8,
   parameter int                    ADDR_W     = 4,
   parameter int                    AFULL_LVL  = 12,
   parameter int                    AEMPTY_LVL = 3,
   parameter dcf_pkg::dcf_rd_mode_e READ_MODE  = dcf_pkg::RD_STANDARD
) (
   input  logic              wclk,
   input  logic              wrst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   output logic              wr_almost_full,
   output logic              wr_err,
   output logic [ADDR_W:0]   wr_count,
   input  logic              rclk,
   input  logic              rrst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic              rd_almost_empty,
   output logic              rd_err,
   output logic [ADDR_W:0]   rd_count
);
   localparam int DEPTH = 1 << ADDR_W;

   if (DATA_W < 1) begin : g_bad_dw
      $error("DATA_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_aw
      $error("ADDR_W must lie in 2..12");
   end
   if (AFULL_LVL < 1 || AFULL_LVL > DEPTH) begin : g_bad_af
      $error("AFULL_LVL must lie in 1..depth");
   end
   if (AEMPTY_LVL < 0 || AEMPTY_LVL > DEPTH - 1) begin : g_bad_ae
      $error("AEMPTY_LVL must lie in 0..depth-1");
   end

   logic [ADDR_W:0]   w_ptr_bin, w_ptr_gray, r_ptr_bin, r_ptr_gray;
   logic [ADDR_W:0]   wptr_at_r, rptr_at_w;
   logic [ADDR_W-1:0] mem_raddr;
   logic [DATA_W-1:0] mem_rdata;
   logic              mem_we;

   dcf_wr_side #(.ADDR_W(ADDR_W), .AFULL_LVL(AFULL_LVL)) u_wr (
      .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rptr_sync(rptr_at_w),
      .wptr_bin(w_ptr_bin), .wptr_gray(w_ptr_gray), .mem_we(mem_we),
      .full(wr_full), .afull(wr_almost_full), .werr(wr_err), .wcount(wr_count)
   );

   dcf_ptr_sync #(.PW(ADDR_W + 1)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .gray_in(r_ptr_gray), .bin_out(rptr_at_w)
   );

   dcf_ptr_sync #(.PW(ADDR_W + 1)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .gray_in(w_ptr_gray), .bin_out(wptr_at_r)
   );

   dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .wclk(wclk), .we(mem_we), .waddr(w_ptr_bin[ADDR_W-1:0]), .wdata(wr_data),
      .raddr(mem_raddr), .rdata(mem_rdata)
   );

   dcf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AEMPTY_LVL(AEMPTY_LVL),
                 .READ_MODE(READ_MODE)) u_rd (
      .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wptr_sync(wptr_at_r),
      .mem_rdata(mem_rdata), .raddr(mem_raddr), .rptr_bin(r_ptr_bin),
      .rptr_gray(r_ptr_gray), .rd_data(rd_data), .empty(rd_empty),
      .aempty(rd_almost_empty), .rerr(rd_err), .rcount(rd_count)
   );
endmodule

// File: rtl/dual_clock_fifo_chk.sv
module dual_clock_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              wclk,
   input logic              wrst_n,
   input logic              wr_en,
   input logic              wr_full,
   input logic              wr_almost_full,
   input logic              wr_err,
   input logic [ADDR_W:0]   wr_count,
   input logic [ADDR_W:0]   wptr,
   input logic              rclk,
   input logic              rrst_n,
   input logic              rd_en,
   input logic              rd_empty,
   input logic              rd_err,
   input logic [DATA_W-1:0] rd_data,
   input logic [ADDR_W:0]   rd_count
);
   localparam int DEPTH = 1 << ADDR_W;

   assert_werr_on_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wr_en && wr_full) |=> wr_err);

   assert_wptr_hold_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
      (wr_en && wr_full) |=> $stable(wptr));

   assert_wcount_bound_R10: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_count <= (ADDR_W+1)'(DEPTH));

   assert_full_has_afull_R6: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_full |-> wr_almost_full);

   assert_werr_cause_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_err |-> $past(wr_en && wr_full));

   assert_rerr_on_underflow_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rd_en && rd_empty) |=> rd_err);

   assert_rerr_cause_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
      rd_err |-> $past(rd_en && rd_empty));

   assert_rcount_bound_R11: assert property (@(posedge rclk) disable iff (!rrst_n)
      rd_count <= (ADDR_W+1)'(DEPTH + 1));

   assert_data_hold_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
      (!rd_en && !rd_empty) |=> $stable(rd_data));
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_full(wr_full),
   .wr_almost_full(wr_almost_full), .wr_err(wr_err), .wr_count(wr_count),
   .wptr(w_ptr_bin), .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en),
   .rd_empty(rd_empty), .rd_err(rd_err), .rd_data(rd_data), .rd_count(rd_count)
);

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;
   import dcf_pkg::*;

   localparam int DW = 8, AW = 4, DEPTH = 16, AF = 12, AE = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          wen = 1'b0, ren = 1'b0;
   logic [DW-1:0] din = '0;

   logic          full_o [2], afull_o [2], werr_o [2];
   logic          empty_o [2], aempty_o [2], rerr_o [2];
   logic [AW:0]   wcnt_o [2], rcnt_o [2];
   logic [DW-1:0] dout_o [2];

   dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .AFULL_LVL(AF), .AEMPTY_LVL(AE),
                     .READ_MODE(RD_STANDARD)) i_dual_clock_fifo (
      .wclk(clk), .wrst_n(rst_n), .wr_en(wen), .wr_data(din),
      .wr_full(full_o[0]), .wr_almost_full(afull_o[0]), .wr_err(werr_o[0]),
      .wr_count(wcnt_o[0]), .rclk(clk), .rrst_n(rst_n), .rd_en(ren),
      .rd_data(dout_o[0]), .rd_empty(empty_o[0]), .rd_almost_empty(aempty_o[0]),
      .rd_err(rerr_o[0]), .rd_count(rcnt_o[0])
   );

   dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .AFULL_LVL(AF), .AEMPTY_LVL(AE),
                     .READ_MODE(RD_FALLTHRU)) i_dual_clock_fifo_fwft (
      .wclk(clk), .wrst_n(rst_n), .wr_en(wen), .wr_data(din),
      .wr_full(full_o[1]), .wr_almost_full(afull_o[1]), .wr_err(werr_o[1]),
      .wr_count(wcnt_o[1]), .rclk(clk), .rrst_n(rst_n), .rd_en(ren),
      .rd_data(dout_o[1]), .rd_empty(empty_o[1]), .rd_almost_empty(aempty_o[1]),
      .rd_err(rerr_o[1]), .rd_count(rcnt_o[1])
   );

   int vectors = 0, miscompares = 0;
   bit done = 1'b0;

   // behavioural model state, one set per read mode
   int        wr_tot [2], rd_tot [2], ws1 [2], ws2 [2], rs1 [2], rs2 [2];
   int        ov [2], dm [2], we_m [2], re_m [2];
   int        mq [2][256];

   task automatic chk(input string req, input string nm, input int m, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s mode%0d: actual %0d expected %0d at %0t", req, nm, m, act, exp, $time);
      end
   endtask

   task automatic check_all();
      for (int m = 0; m < 2; m++) begin
         int wc, mc, rc, e;
         wc = wr_tot[m] - rs2[m];
         mc = ws2[m] - rd_tot[m];
         if (m == 0) begin e = (mc == 0); rc = mc; end
         else        begin e = (ov[m] == 0); rc = mc + ov[m]; end
         chk("R10", "wr_count", m, int'(wcnt_o[m]), wc);
         chk("R3", "wr_full", m, int'(full_o[m]), int'(wc == DEPTH));
         chk("R6", "wr_almost_full", m, int'(afull_o[m]), int'(wc >= AF));
         chk("R3 R5", "wr_err", m, int'(werr_o[m]), we_m[m]);
         chk(m == 0 ? "R8" : "R9", "rd_empty", m, int'(empty_o[m]), e);
         chk("R11", "rd_count", m, int'(rcnt_o[m]), rc);
         chk("R7", "rd_almost_empty", m, int'(aempty_o[m]), int'(rc <= AE));
         chk("R4 R5", "rd_err", m, int'(rerr_o[m]), re_m[m]);
         chk("R2", "rd_data", m, int'(dout_o[m]), dm[m]);
      end
   endtask

   task automatic model_step(input bit w, input bit r, input int d);
      for (int m = 0; m < 2; m++) begin
         int wc, mc, o_wr, o_rd;
         wc = wr_tot[m] - rs2[m];
         mc = ws2[m] - rd_tot[m];
         o_wr = wr_tot[m];
         o_rd = rd_tot[m];
         ws2[m] = ws1[m]; ws1[m] = o_wr;
         rs2[m] = rs1[m]; rs1[m] = o_rd;
         we_m[m] = int'(w && wc == DEPTH);
         if (w && wc != DEPTH) begin
            mq[m][o_wr % 256] = d;
            wr_tot[m]++;
         end
         if (m == 0) begin
            re_m[m] = int'(r && mc == 0);
            if (r && mc > 0) begin dm[m] = mq[m][o_rd % 256]; rd_tot[m]++; end
         end else begin
            re_m[m] = int'(r && ov[m] == 0);
            if ((ov[m] == 0 || r) && mc > 0) begin
               dm[m] = mq[m][o_rd % 256]; rd_tot[m]++; ov[m] = 1;
            end else if (r && ov[m] == 1) ov[m] = 0;
         end
      end
   endtask

   task automatic cycle(input bit w, input bit r, input int d);
      @(negedge clk);
      check_all();
      model_step(w, r, d);
      wen = w; ren = r; din = DW'(d);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      for (int m = 0; m < 2; m++) begin
         wr_tot[m] = 0; rd_tot[m] = 0; ws1[m] = 0; ws2[m] = 0; rs1[m] = 0; rs2[m] = 0;
         ov[m] = 0; dm[m] = 0; we_m[m] = 0; re_m[m] = 0;
         for (int i = 0; i < 256; i++) mq[m][i] = 0;
      end
      // R1: state while both resets are held
      repeat (3) @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         chk("R1", "rd_empty", m, int'(empty_o[m]), 1);
         chk("R1", "wr_full", m, int'(full_o[m]), 0);
         chk("R1", "wr_count", m, int'(wcnt_o[m]), 0);
         chk("R1", "rd_count", m, int'(rcnt_o[m]), 0);
         chk("R1", "wr_err", m, int'(werr_o[m]), 0);
         chk("R1", "rd_err", m, int'(rerr_o[m]), 0);
      end
      rst_n = 1'b1;
      // R4/R5: reads into an empty buffer, then idle so strobes must drop
      for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 0);
      for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 0);
      // R9 vs R8: one word, no read request; fall-through shows it on its own
      cycle(1'b1, 1'b0, 8'hA5);
      for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0, 0);
      cycle(1'b0, 1'b1, 0);
      for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 0);
      // R3/R6: fill past capacity with no reads
      for (int i = 0; i < 22; i++) cycle(1'b1, 1'b0, 16 + i);
      for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 0);
      // R2/R7/R4: drain past empty
      for (int i = 0; i < 24; i++) cycle(1'b0, 1'b1, 0);
      for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 0);
      // random traffic at several densities
      for (int s = 0; s < 4; s++) begin
         int wp, rp;
         wp = (s == 0) ? 70 : (s == 1) ? 30 : (s == 2) ? 50 : 90;
         rp = (s == 0) ? 30 : (s == 1) ? 70 : (s == 2) ? 50 : 90;
         for (int i = 0; i < 600; i++)
            cycle($urandom_range(99) < wp, $urandom_range(99) < rp, int'($urandom_range(255)));
      end
      for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, 0);
      cycle(1'b0, 1'b0, 0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog R1: actual running expected finished");
         summary();
         $finish;
      end
   end
endmodule